// File: doc/BRIEF.md
# Keyed windowed watchdog timer

This block is a memory-mapped watchdog with a 32-bit register port driven by simple write and read strobes. A magic word written to its control register arms it and loads a down-counter from a 12-bit timeout field. From then on, software must feed it with an ordered pair of key words. The counter can only be fed inside an open window at the end of each period. The window is a power-of-two fraction of the period.

A feed outside the window is a violation, and so is a counter that runs out unfed. A violation sets a sticky status flag and drives one of two outputs: a reset request or a non-maskable interrupt request, chosen by a reaction register. Once armed, the watchdog stays armed until a system reset. A debug-halt input can freeze the count when a global control bit allows it.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, every readable register returns 0, the watchdog is disarmed, the count is 0, and both `rst_req` and `nmi_req` are low.
- R2: Writing 0xA98559DA to offset 0x90 while disarmed arms the watchdog and loads the count with (timeout << 13) | 0x1FFF, using the 12-bit timeout at offset 0x94. The live count reads at 0xA0 and drops by one per running cycle.
- R3: Once armed, the watchdog cannot be disarmed. Writing 0x5312ACED to 0x90 only discards a half-entered key pair. Status bit 3 (read-only) reads 1 while armed.
- R4: Writing 0x0000E51A and then 0x0000A35C to offset 0x9C while armed completes a feed. The count is reloaded on the edge of the second write, with the timeout value current before that edge.
- R5: A key write that is neither 0xE51A nor an 0xA35C directly after 0xE51A completes no feed, clears the pair state and sets status bit 2. While disarmed, key writes are ignored.
- R6: The window size code at 0xA8 selects the shift k as 0x5→0, 0x50→1, 0x500→2, 0x5000→3, 0x50000→4, 0x500000→5. A feed while count > (reload >> k) is early: it sets status bit 0, raises the reaction and still reloads.
- R7: A running count at 0 with no feed in that cycle is an expiry. It sets status bit 1, raises the reaction and reloads the count.
- R8: If the reaction value at 0xA4 is 0xA when a violation occurs, `nmi_req` is raised; any other value raises `rst_req`. The raised output stays high while status bit 0 or bit 1 is set.
- R9: Writing ones to status bits 0 to 2 at 0x98 clears those flags. When bits 0 and 1 are both clear, both request outputs drop on that edge.
- R10: With bit 15 of the global control register (0x00) clear, `dbg_halt` high freezes the count. With bit 15 set, the count keeps running.
- R11: A window code outside the six listed values behaves as the full window (k = 0).
- R12: The global control register reads back bit 15 only. The timeout field reads back its low 12 bits. The reaction and window registers read back all 32 bits. Reads of 0x90, 0x9C and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (combinational read data) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when `rd_en` is low |
| dbg_halt | input | 1 | Debug halt request |
| rst_req | output | 1 | Reset request after a violation |
| nmi_req | output | 1 | Non-maskable interrupt request after a violation |

## Verification
A behavioural reference model steps in lockstep with the design and is compared on every clock. The bench targets these cases:
- Feeds exactly around the window threshold at several window sizes. A wrong comparison direction or shift would flag good feeds as early, or let early ones pass.
- A pair broken by a stray word or by the disable code. A design that forgot the pair state would feed the watchdog on a lone second word.
- A timeout change between arming and feeding. A design that applied the new value at the wrong edge would reload a different count.
- Expiry with an unrecognised reaction code, and debug halt with both settings of the run bit. Errors here show up as the wrong request pin, or as a count that moves or freezes when it should not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam logic [31:0] ARM_CODE    = 32'hA985_59DA;
   localparam logic [31:0] DISARM_CODE = 32'h5312_ACED;
   localparam logic [31:0] FEED_WORD_A = 32'h0000_E51A;
   localparam logic [31:0] FEED_WORD_B = 32'h0000_A35C;
   localparam logic [31:0] REACT_NMI   = 32'h0000_000A;

   localparam logic [7:0] OFS_GCTRL   = 8'h00;
   localparam logic [7:0] OFS_CTRL    = 8'h90;
   localparam logic [7:0] OFS_TIMEOUT = 8'h94;
   localparam logic [7:0] OFS_STATUS  = 8'h98;
   localparam logic [7:0] OFS_KEY     = 8'h9C;
   localparam logic [7:0] OFS_COUNT   = 8'hA0;
   localparam logic [7:0] OFS_REACT   = 8'hA4;
   localparam logic [7:0] OFS_WINDOW  = 8'hA8;

   localparam int RUN_BIT  = 15;
   localparam int NUM_FRAC = 6;
   localparam int FL_EARLY = 0;
   localparam int FL_EXP   = 1;
   localparam int FL_KEY   = 2;

   typedef enum logic {KS_IDLE, KS_ARMED} key_state_t;

   // window code to right-shift of the reload value; unknown codes mean full window
   function automatic logic [2:0] win_shift(input logic [31:0] code);
      case (code)
         32'h0000_0005: win_shift = 3'd0;
         32'h0000_0050: win_shift = 3'd1;
         32'h0000_0500: win_shift = 3'd2;
         32'h0000_5000: win_shift = 3'd3;
         32'h0005_0000: win_shift = 3'd4;
         32'h0050_0000: win_shift = 3'd5;
         default:       win_shift = 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
   import wdt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              key_wr,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              feed,
   output logic              key_err
);
   key_state_t st_q;
   logic is_a, is_b;

   assign is_a = (wdata == DATA_W'(FEED_WORD_A));
   assign is_b = (wdata == DATA_W'(FEED_WORD_B));

   always_comb begin
      feed    = en && key_wr && is_b && (st_q == KS_ARMED);
      key_err = en && key_wr && !is_a && !feed;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= KS_IDLE;
      else if (ctrl_wr && wdata == DATA_W'(DISARM_CODE))
         st_q <= KS_IDLE;
      else if (en && key_wr)
         st_q <= is_a ? KS_ARMED : KS_IDLE;
   end

   // R5
   no_feed_after_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && key_wr && !is_a) |=> !feed);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int PRELOAD_W = 12,
   parameter int SHIFT     = 13,
   localparam int CNT_W    = PRELOAD_W + SHIFT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm,
   input  logic                 en,
   input  logic                 run,
   input  logic                 feed,
   input  logic [PRELOAD_W-1:0] preload,
   input  logic [31:0]          win_code,
   output logic [CNT_W-1:0]     cnt_q,
   output logic                 early_ev,
   output logic                 exp_ev
);
   localparam int SEL_W = $clog2(NUM_FRAC);
   localparam int NSLOT = 2 ** SEL_W;

   logic [CNT_W-1:0] reload, thr;
   logic [CNT_W-1:0] thr_v [NSLOT];
   logic [SEL_W-1:0] sel;

   assign reload = {preload, {SHIFT{1'b1}}};

   for (genvar i = 0; i < NSLOT; i++) begin : g_frac
      if (i < NUM_FRAC) begin : g_real
         assign thr_v[i] = reload >> i;
      end else begin : g_pad
         assign thr_v[i] = reload;
      end
   end

   assign sel = SEL_W'(win_shift(win_code));
   assign thr = thr_v[sel];

   always_comb begin
      early_ev = en && feed && (cnt_q > thr);
      exp_ev   = en && !feed && run && (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (arm)
         cnt_q <= reload;
      else if (en) begin
         if (feed)
            cnt_q <= reload;
         else if (run)
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - CNT_W'(1);
      end
   end

   // R2
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && run && !feed && !arm && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !run && !feed) |=> $stable(cnt_q));
   // R4
   feed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && feed) |=> cnt_q == $past(reload));
   // R7
   exp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_ev |=> cnt_q == $past(reload));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int PRELOAD_W = 12,
   parameter int CNT_W     = 25
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic [CNT_W-1:0]     cnt,
   input  logic                 early_ev,
   input  logic                 exp_ev,
   input  logic                 key_err,
   output logic                 en_q,
   output logic                 run_dbg_q,
   output logic [PRELOAD_W-1:0] preload_q,
   output logic [31:0]          win_q,
   output logic                 arm,
   output logic                 key_wr,
   output logic                 ctrl_wr,
   output logic                 rst_req,
   output logic                 nmi_req
);
   logic [31:0] react_q;
   logic [2:0]  flags_q, fl_set, fl_clr;
   logic        nmi_sel_q, pend;
   logic        wr_g, wr_t, wr_s, wr_r, wr_w;

   assign wr_g    = wr_en && addr == ADDR_W'(OFS_GCTRL);
   assign ctrl_wr = wr_en && addr == ADDR_W'(OFS_CTRL);
   assign wr_t    = wr_en && addr == ADDR_W'(OFS_TIMEOUT);
   assign wr_s    = wr_en && addr == ADDR_W'(OFS_STATUS);
   assign key_wr  = wr_en && addr == ADDR_W'(OFS_KEY);
   assign wr_r    = wr_en && addr == ADDR_W'(OFS_REACT);
   assign wr_w    = wr_en && addr == ADDR_W'(OFS_WINDOW);
   assign arm     = ctrl_wr && !en_q && wdata == DATA_W'(ARM_CODE);

   always_comb begin
      fl_set           = '0;
      fl_set[FL_EARLY] = early_ev;
      fl_set[FL_EXP]   = exp_ev;
      fl_set[FL_KEY]   = key_err;
      fl_clr           = wr_s ? wdata[2:0] : 3'b000;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         run_dbg_q <= 1'b0;
         preload_q <= '0;
         react_q   <= '0;
         win_q     <= '0;
         flags_q   <= '0;
         nmi_sel_q <= 1'b0;
      end else begin
         if (arm)  en_q      <= 1'b1;
         if (wr_g) run_dbg_q <= wdata[RUN_BIT];
         if (wr_t) preload_q <= wdata[PRELOAD_W-1:0];
         if (wr_r) react_q   <= wdata[31:0];
         if (wr_w) win_q     <= wdata[31:0];
         flags_q <= (flags_q & ~fl_clr) | fl_set;
         if (early_ev || exp_ev)
            nmi_sel_q <= (react_q == REACT_NMI);
      end
   end

   assign pend    = flags_q[FL_EARLY] | flags_q[FL_EXP];
   assign rst_req = pend & ~nmi_sel_q;
   assign nmi_req = pend & nmi_sel_q;

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            ADDR_W'(OFS_GCTRL):   rdata[RUN_BIT] = run_dbg_q;
            ADDR_W'(OFS_TIMEOUT): rdata = DATA_W'(preload_q);
            ADDR_W'(OFS_STATUS):  rdata = DATA_W'({en_q, flags_q});
            ADDR_W'(OFS_COUNT):   rdata = DATA_W'(cnt);
            ADDR_W'(OFS_REACT):   rdata = DATA_W'(react_q);
            ADDR_W'(OFS_WINDOW):  rdata = DATA_W'(win_q);
            default:              rdata = '0;
         endcase
      end
   end

   // R3
   arm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);
   // R8
   nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_req) |-> $past(react_q) == REACT_NMI);
   // R9
   req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_s && wdata[1:0] == 2'b11 && !early_ev && !exp_ev) |=> (!rst_req && !nmi_req));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import wdt_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int PRELOAD_W = 12,
   parameter int SHIFT     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              dbg_halt,
   output logic              rst_req,
   output logic              nmi_req
);
   localparam int CNT_W = PRELOAD_W + SHIFT;

   if (DATA_W != 32) begin : g_bad_data
      $error("keyed_wdog: DATA_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("keyed_wdog: ADDR_W must be at least 8");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("keyed_wdog: PRELOAD_W + SHIFT exceeds DATA_W");
   end
   if (SHIFT < NUM_FRAC) begin : g_bad_shift
      $error("keyed_wdog: SHIFT too small for the narrowest window");
   end

   logic                 en, run_dbg, run, arm, key_wr, ctrl_wr;
   logic                 feed, key_err, early_ev, exp_ev;
   logic [PRELOAD_W-1:0] preload;
   logic [31:0]          win_code;
   logic [CNT_W-1:0]     cnt;

   assign run = run_dbg | ~dbg_halt;

   wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .cnt(cnt), .early_ev(early_ev),
      .exp_ev(exp_ev), .key_err(key_err), .en_q(en), .run_dbg_q(run_dbg),
      .preload_q(preload), .win_q(win_code), .arm(arm), .key_wr(key_wr),
      .ctrl_wr(ctrl_wr), .rst_req(rst_req), .nmi_req(nmi_req));

   wdt_keyseq #(.DATA_W(DATA_W)) u_keys (
      .clk(clk), .rst_n(rst_n), .en(en), .key_wr(key_wr), .ctrl_wr(ctrl_wr),
      .wdata(wdata), .feed(feed), .key_err(key_err));

   wdt_core #(.PRELOAD_W(PRELOAD_W), .SHIFT(SHIFT)) u_core (
      .clk(clk), .rst_n(rst_n), .arm(arm), .en(en), .run(run), .feed(feed),
      .preload(preload), .win_code(win_code), .cnt_q(cnt),
      .early_ev(early_ev), .exp_ev(exp_ev));
endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, dbg_halt = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_req, nmi_req;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   // reference model state
   int          m_cnt = 0, m_pre = 0;
   bit          m_en = 0, m_g = 0, m_arm = 0, m_fe = 0, m_fx = 0, m_fk = 0, m_ns = 0;
   logic [31:0] m_rx = '0, m_ws = '0;

   always #4 clk = ~clk;

   keyed_wdog u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .dbg_halt(dbg_halt), .rst_req(rst_req), .nmi_req(nmi_req));

   function automatic int mrel(int pre);
      return pre * 8192 + 8191;
   endfunction

   function automatic int mthr(int pre, logic [31:0] ws);
      int k;
      case (ws)
         32'h50:     k = 1;
         32'h500:    k = 2;
         32'h5000:   k = 3;
         32'h50000:  k = 4;
         32'h500000: k = 5;
         default:    k = 0;
      endcase
      return mrel(pre) / (1 << k);
   endfunction

   function automatic logic [31:0] mread(logic [7:0] a);
      case (a)
         8'h00: return m_g ? 32'h8000 : 32'h0;
         8'h94: return 32'(m_pre);
         8'h98: return {28'h0, m_en, m_fk, m_fx, m_fe};
         8'hA0: return 32'(m_cnt);
         8'hA4: return m_rx;
         8'hA8: return m_ws;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      int rl, th, o_pre;
      bit o_en, o_g, load, feed, early, expv, bad;
      logic [31:0] o_rx, o_ws;
      logic [2:0]  clr;
      cyc++;
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_en = 0; m_g = 0; m_arm = 0;
         m_fe = 0; m_fx = 0; m_fk = 0; m_ns = 0; m_rx = '0; m_ws = '0;
      end else begin
         o_pre = m_pre; o_en = m_en; o_g = m_g; o_rx = m_rx; o_ws = m_ws;
         rl = mrel(o_pre); th = mthr(o_pre, o_ws);
         load = 0; feed = 0; early = 0; expv = 0; bad = 0; clr = 3'b000;
         if (wr_en) begin
            case (addr)
               8'h00: m_g = wdata[15];
               8'h90: begin
                  if (wdata == 32'hA98559DA && !m_en) begin m_en = 1; load = 1; end
                  else if (wdata == 32'h5312ACED) m_arm = 0;
               end
               8'h94: m_pre = int'(wdata[11:0]);
               8'h98: clr = wdata[2:0];
               8'h9C: if (o_en) begin
                  if (wdata == 32'hE51A) m_arm = 1;
                  else if (wdata == 32'hA35C && m_arm) begin feed = 1; m_arm = 0; end
                  else begin m_arm = 0; bad = 1; end
               end
               8'hA4: m_rx = wdata;
               8'hA8: m_ws = wdata;
               default: ;
            endcase
         end
         if (load) m_cnt = rl;
         else if (o_en) begin
            if (feed) begin
               if (m_cnt > th) early = 1;
               m_cnt = rl;
            end else if (!dbg_halt || o_g) begin
               if (m_cnt == 0) begin expv = 1; m_cnt = rl; end
               else m_cnt = m_cnt - 1;
            end
         end
         m_fe = (m_fe && !clr[0]) || early;
         m_fx = (m_fx && !clr[1]) || expv;
         m_fk = (m_fk && !clr[2]) || bad;
         if (early || expv) m_ns = (o_rx == 32'hA);
      end
      if (cyc > 150000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish actual=%0d expected<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R8: request outputs compared with the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done)
         chk("R8", {30'h0, rst_req, nmi_req},
             {30'h0, (m_fe || m_fx) && !m_ns, (m_fe || m_fx) && m_ns});
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      chk(tag, rdata, mread(a));
      rd_en = 1'b0;
   endtask

   task automatic feed_pair();
      wr(8'h9C, 32'hE51A);
      wr(8'h9C, 32'hA35C);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1
      rd(8'h00, "R1"); rd(8'h94, "R1"); rd(8'h98, "R1"); rd(8'hA0, "R1");
      rd(8'hA4, "R1"); rd(8'hA8, "R1");
      chk("R1", {30'h0, rst_req, nmi_req}, 32'h0);
      // R12
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, "R12");
      wr(8'h94, 32'hFFFF_F000); rd(8'h94, "R12");
      wr(8'hA4, 32'h5); rd(8'hA4, "R12");
      wr(8'hA8, 32'h5); rd(8'hA8, "R12");
      rd(8'h90, "R12"); rd(8'h9C, "R12");
      // R5: key write while disarmed ignored
      wr(8'h9C, 32'h1234); rd(8'h98, "R5");
      // R2: arm and count
      wr(8'h90, 32'hA98559DA); rd(8'hA0, "R2");
      repeat (20) @(negedge clk);
      rd(8'hA0, "R2"); rd(8'h98, "R3");
      // R4: timeout change then feed
      wr(8'h94, 32'h1); feed_pair(); rd(8'hA0, "R4");
      // R5 and R9
      wr(8'h9C, 32'h1234); rd(8'h98, "R5");
      wr(8'h98, 32'h4); rd(8'h98, "R9");
      wr(8'h9C, 32'hA35C); rd(8'h98, "R5"); rd(8'hA0, "R5");
      wr(8'h98, 32'h7);
      // R3: disable code breaks the pair, watchdog stays armed
      wr(8'h9C, 32'hE51A); wr(8'h90, 32'h5312ACED); wr(8'h9C, 32'hA35C);
      rd(8'h98, "R3"); rd(8'hA0, "R3");
      wr(8'h98, 32'h7); rd(8'h98, "R3");
      // R6: 50% window, early feed with reset reaction
      wr(8'hA8, 32'h50); feed_pair(); rd(8'h98, "R6");
      chk("R8", {31'h0, rst_req}, 32'h1);
      wr(8'h98, 32'h1);
      chk("R9", {30'h0, rst_req, nmi_req}, 32'h0);
      // R6: in-window feed under NMI reaction
      wr(8'hA4, 32'hA);
      while (m_cnt > mthr(m_pre, m_ws) - 10) @(negedge clk);
      feed_pair(); rd(8'h98, "R6");
      feed_pair(); rd(8'h98, "R6");
      chk("R8", {31'h0, nmi_req}, 32'h1);
      wr(8'h98, 32'h7);
      // R6: narrowest window
      wr(8'hA8, 32'h500000); feed_pair(); rd(8'h98, "R6"); wr(8'h98, 32'h7);
      while (m_cnt > mthr(m_pre, m_ws) - 5) @(negedge clk);
      feed_pair(); rd(8'h98, "R6");
      // R11: unknown window code is full window
      wr(8'hA8, 32'h7); feed_pair(); rd(8'h98, "R11");
      // R7: expiry with unknown reaction code gives reset
      wr(8'hA4, 32'h3);
      while (!m_fx) @(negedge clk);
      rd(8'h98, "R7");
      chk("R7", {30'h0, rst_req, nmi_req}, 32'h2);
      wr(8'h98, 32'h7);
      // R10: debug halt
      wr(8'h00, 32'h0); dbg_halt = 1'b1;
      rd(8'hA0, "R10"); repeat (10) @(negedge clk); rd(8'hA0, "R10");
      wr(8'h00, 32'h8000); repeat (10) @(negedge clk); rd(8'hA0, "R10");
      dbg_halt = 1'b0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule